// File: doc/BRIEF.md
# Regenerative Bit Memory for Stochastic Decoding

In a stochastic decoder, every node on the decoding graph emits one bit per decoding cycle, and the probability that node carries is the fraction of ones in its stream. Feedback loops in the graph can lock a stream at a constant 0 or 1. This block sits on one edge of the graph and breaks that lock. Each cycle the producing node marks its bit as regenerative or not. A regenerative bit is one whose value is not forced by a stuck condition.

A regenerative bit is passed on and is also pushed into a small history register. When the bit is not regenerative, the block does not use it and does not store it. It replays an earlier regenerative bit instead, chosen by a random index that an external generator supplies. The history therefore follows the statistics of the live stream, and random reads from it decorrelate the output. A decoder needs one instance per edge. At reset the history holds alternating ones and zeros, so an edge starts out representing a probability of one half.

Top module: `stoch_edge_mem`

## Requirements
- R1: After a synchronous reset, `bit_out` is 0 and history entry k holds k mod 2, for k = 0 (newest) up to DEPTH-1 (oldest).
- R2: On an enabled cycle with `regen` high, `bit_out` takes the value of `bit_in` at that clock edge, so the bit appears one cycle later.
- R3: On an enabled cycle with `regen` high, `bit_in` is written into entry 0, every entry k moves to entry k+1, and the old entry DEPTH-1 is discarded.
- R4: On an enabled cycle with `regen` low, `bit_out` takes the value of history entry `rand_idx` (entry 0 is the newest bit), and `bit_in` is not stored.
- R5: When DEPTH is not a power of two, an index at or above DEPTH selects entry `rand_idx` - DEPTH.
- R6: While `en` is low, the history does not change and `bit_out` keeps its value, whatever the values of `bit_in`, `regen` and `rand_idx`.
- R7: Reset takes priority over `en` and `regen`. A reset cycle with a regenerative bit presented still gives the R1 state.
- R8: Every history entry can be read, including entry DEPTH-1. After DEPTH or more writes, entry DEPTH-1 holds the bit written DEPTH-1 writes before the newest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the block by one decoding cycle |
| bit_in | input | 1 | Incoming stochastic bit |
| regen | input | 1 | High when `bit_in` is regenerative |
| rand_idx | input | IDX_W | Random history index, IDX_W = clog2(DEPTH) |
| bit_out | output | 1 | Registered output bit |

## Verification
The hardest state to reach from the ports is a fully known history. The bench can only see the history by replaying it through non-regenerative reads. The stimulus writes more than DEPTH regenerative bits and then sweeps every index, including the oldest slot, with `regen` low and unused values on `bit_in`. Doing this reads back the whole history and shows at the same time that the offered bits were not stored. Indices at and above DEPTH only matter on a history whose depth is not a power of two. A second instance with depth 24 receives the same stimulus, so those indices exercise the wrap.

// File: rtl/emem_pkg.sv
package emem_pkg;

  // Action taken by the edge memory in one clock cycle.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,  // disabled: keep state and output
    OP_LOAD = 2'd1,  // regenerative: forward and record
    OP_PICK = 2'd2   // stalled: replay a stored bit
  } emem_op_e;

endpackage

// File: rtl/emem_idx_wrap.sv
module emem_idx_wrap #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] raw_idx,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W:0] DEPTH_V = (IDX_W + 1)'(DEPTH);

  generate
    if ((1 << IDX_W) == DEPTH) begin : g_pow2
      assign idx = raw_idx;
    end else begin : g_fold
      // raw_idx is below 2*DEPTH, so one subtraction is enough
      always_comb begin
        if ({1'b0, raw_idx} >= DEPTH_V) idx = raw_idx - DEPTH_V[IDX_W-1:0];
        else                            idx = raw_idx;
      end
    end
  endgenerate

  // R5: the folded index always selects an existing entry
  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, idx} < DEPTH_V);

endmodule

// File: rtl/emem_history.sv
module emem_history #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             din,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [DEPTH-1:0] cells;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_cell
      localparam logic INIT = 1'(k % 2);
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)       cells[k] <= INIT;
          else if (push) cells[k] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)       cells[k] <= INIT;
          else if (push) cells[k] <= cells[k-1];
        end
      end
    end
  endgenerate

  assign rd_bit = cells[rd_idx];

  // R3: the pushed bit lands in the newest slot
  a_r3_newest_slot: assert property (@(posedge clk) disable iff (rst)
    push |=> cells[0] == $past(din));

  // R3: entries age by one slot per push
  a_r3_age_one_slot: assert property (@(posedge clk) disable iff (rst)
    push |=> cells[DEPTH-1:1] == $past(cells[DEPTH-2:0]));

  // R4, R6: without a push the history is frozen
  a_r6_history_frozen: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(cells));

endmodule

// File: rtl/emem_out_reg.sv
module emem_out_reg
  import emem_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  emem_op_e op,
  input  logic     live_bit,
  input  logic     replay_bit,
  output logic     q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD: q <= live_bit;
        OP_PICK: q <= replay_bit;
        default: q <= q;
      endcase
    end
  end

  // R2: a regenerative bit is forwarded
  a_r2_forward_live: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> q == $past(live_bit));

  // R4: a stall replays the addressed history bit
  a_r4_replay_history: assert property (@(posedge clk) disable iff (rst)
    op == OP_PICK |=> q == $past(replay_bit));

  // R6: disabled cycles keep the output
  a_r6_output_held: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(q));

endmodule

// File: rtl/stoch_edge_mem.sv
module stoch_edge_mem
  import emem_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bit_in,
  input  logic             regen,
  input  logic [IDX_W-1:0] rand_idx,
  output logic             bit_out
);

  emem_op_e         op;
  logic [IDX_W-1:0] idx;
  logic             hist_bit;

  always_comb begin
    if (!en)       op = OP_HOLD;
    else if (regen) op = OP_LOAD;
    else           op = OP_PICK;
  end

  emem_idx_wrap #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wrap (
    .clk     (clk),
    .rst     (rst),
    .raw_idx (rand_idx),
    .idx     (idx)
  );

  emem_history #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .push   (op == OP_LOAD),
    .din    (bit_in),
    .rd_idx (idx),
    .rd_bit (hist_bit)
  );

  emem_out_reg u_out (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .live_bit   (bit_in),
    .replay_bit (hist_bit),
    .q          (bit_out)
  );

  // R6: port-level check that a disabled cycle leaves the output alone
  a_r6_port_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> bit_out == $past(bit_out));

endmodule

// File: tb/stoch_edge_mem_test.sv
`timescale 1ns/100ps
module stoch_edge_mem_test;

  localparam int D0 = 32;
  localparam int D1 = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, bit_in = 1'b0, regen = 1'b0;
  logic [IW-1:0] rand_idx = '0;
  logic out0, out1;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  logic m0 [D0];
  logic m1 [D1];
  logic e0, e1;

  always #2.5 clk = ~clk;

  stoch_edge_mem #(.DEPTH(D0)) uut (
    .clk(clk), .rst(rst), .en(en), .bit_in(bit_in), .regen(regen),
    .rand_idx(rand_idx), .bit_out(out0));

  stoch_edge_mem #(.DEPTH(D1)) uut_odd (
    .clk(clk), .rst(rst), .en(en), .bit_in(bit_in), .regen(regen),
    .rand_idx(rand_idx), .bit_out(out1));

  function automatic int fold(input int a, input int d);
    return (a >= d) ? a - d : a;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < D0; k++) m0[k] = 1'(k % 2);
    for (int k = 0; k < D1; k++) m1[k] = 1'(k % 2);
    e0 = 1'b0;
    e1 = 1'b0;
  endtask

  task automatic do_reset(input logic e, input logic r, input logic b, input string req);
    @(negedge clk);
    rst = 1'b1; en = e; regen = r; bit_in = b;
    @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
    check(out0, e0, req);
    check(out1, e1, req);
  endtask

  task automatic step(input logic e, input logic r, input logic b,
                      input logic [IW-1:0] a, input string req);
    @(negedge clk);
    en = e; regen = r; bit_in = b; rand_idx = a;
    @(posedge clk); #1;
    if (e) begin
      if (r) begin
        e0 = b; e1 = b;
        for (int k = D0 - 1; k > 0; k--) m0[k] = m0[k-1];
        for (int k = D1 - 1; k > 0; k--) m1[k] = m1[k-1];
        m0[0] = b; m1[0] = b;
      end else begin
        e0 = m0[int'(a)];
        e1 = m1[fold(int'(a), D1)];
      end
    end
    check(out0, e0, req);
    check(out1, e1, req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    do_reset(1'b0, 1'b0, 1'b0, "R1");

    // R1: read the reset pattern back, offering ones that must not be stored
    for (int a = 0; a < 32; a++) step(1'b1, 1'b0, 1'b1, 5'(a), "R1");

    // R2, R3: directed regenerative writes
    step(1'b1, 1'b1, 1'b1, 5'd0, "R2");
    step(1'b1, 1'b1, 1'b0, 5'd0, "R2");
    step(1'b1, 1'b0, 1'b0, 5'd1, "R3");
    step(1'b1, 1'b0, 1'b1, 5'd0, "R3");

    // R6: disabled cycles with busy inputs, then read back
    for (int i = 0; i < 20; i++)
      step(1'b0, 1'($urandom), 1'($urandom), 5'($urandom), "R6");
    for (int a = 0; a < 32; a++) step(1'b1, 1'b0, 1'($urandom), 5'(a), "R6");

    // R8: fill the whole history with random bits, then sweep all indices
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'($urandom), 5'd0, "R3");
    for (int a = 0; a < 32; a++) step(1'b1, 1'b0, 1'($urandom), 5'(a), "R8");
    step(1'b1, 1'b0, 1'b1, 5'd31, "R8");
    // R5: upper indices on the depth-24 instance
    for (int a = 24; a < 32; a++) step(1'b1, 1'b0, 1'b0, 5'(a), "R5");

    // R4: constrained random mix of all three actions
    for (int i = 0; i < 3000; i++) begin
      automatic int sel = $urandom_range(0, 9);
      step(sel != 0, sel < 5, 1'($urandom), 5'($urandom), "R4");
    end

    // R7: reset while a regenerative one is presented, then read back
    step(1'b1, 1'b1, 1'b1, 5'd0, "R2");
    do_reset(1'b1, 1'b1, 1'b1, "R7");
    for (int a = 0; a < 32; a++) step(1'b1, 1'b0, 1'b1, 5'(a), "R7");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule